// File: doc/BRIEF.md
# Page-Aligned Flash Program Sequencer

This block turns one write request into the chain of serial NOR flash commands that stores the data. A request carries a start address, a byte count and a page size. The sequencer checks the request against the device capacity. It then cuts the data into chunks that each stay inside one page. For every chunk it emits a write-enable frame, then a page-program frame carrying the chunk, then status-read frames. It repeats the status read until the busy flag clears. When all chunks are stored, it reports completion.

Frames leave as a byte stream with a last-byte marker toward a separate command engine, which shifts the bits onto the wire. The engine answers each frame with a done pulse, an error flag and the last byte it received. Program data enters through a valid/ready byte stream and passes straight into the program frame. The page size is given per request as a power-of-two exponent.

Top module: `fps_prog_seq`

## Requirements
- R1: `req_ready` is high exactly while no sequence is running, and no frame byte is offered (`cmd_valid` low, `dat_ready` low) while it is high.
- R2: A request whose address is negative (top bit of `req_addr` set) or whose address plus length exceeds `FLASH_BYTES` is answered in the cycle after acceptance with `resp_err` = 1 and produces no frame.
- R3: A request of length zero that is in range is answered in the cycle after acceptance with `resp_err` = 0 and produces no frame.
- R4: Each program chunk holds the smaller of the bytes still to write and the bytes left before the next page boundary, so no chunk spans two pages.
- R5: The page holds 2^`req_pg_log2` bytes; the value 0 selects 256 bytes.
- R6: Every program frame is preceded by a one-byte frame holding 0x06.
- R7: A program frame is 0x02, then address bits 23:16, 15:8 and 7:0, then the chunk's data bytes in stream order, with `cmd_last` on the final data byte.
- R8: After each program frame the block sends two-byte status frames (0x05, 0x00) and repeats them while bit 0 of the returned byte is 1; the other returned bits have no effect.
- R9: A frame that completes with `fr_err` high ends the sequence at once with `resp_err` = 2; no further frame follows.
- R10: When `POLL_LIMIT` consecutive status replies after one chunk show bit 0 set, the sequence ends with `resp_err` = 3; `POLL_LIMIT`-1 busy replies followed by a ready one do not end it.
- R11: Completion is a single-cycle `resp_valid` pulse, with `resp_err` = 0 after the final status read of a fully written request.
- R12: While `cmd_ready` is low the offered frame byte is held, and no data byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted on valid |
| req_addr | input | ADDR_W+1 | Start address, two's complement |
| req_len | input | LEN_W | Byte count |
| req_pg_log2 | input | PGL_W | Page size exponent, 0 selects the default, values above MAX_LOG2 clamp |
| resp_valid | output | 1 | Request finished pulse |
| resp_err | output | 2 | 0 ok, 1 out of range, 2 frame failure, 3 poll timeout |
| dat_valid | input | 1 | Program data byte present |
| dat_ready | output | 1 | Program data byte taken |
| dat_byte | input | 8 | Program data byte |
| cmd_valid | output | 1 | Frame byte present |
| cmd_ready | input | 1 | Command engine takes the byte |
| cmd_byte | output | 8 | Frame byte |
| cmd_last | output | 1 | Final byte of the frame |
| fr_done | input | 1 | Command engine finished a frame |
| fr_err | input | 1 | That frame failed |
| fr_rx | input | 8 | Last byte received during that frame |

## Verification
The bench builds the block with a 16-bit address, an 8 KiB device, a 1 KiB page ceiling and a poll limit of five. These settings make the upper end of the capacity check cheap to reach, both just inside and just beyond it. They also make the timeout boundary reachable in a few polls. Page exponents of 0 and 4 are driven, so the default 256-byte page and a 16-byte page each show head, full and tail chunks. The engine model stalls `cmd_ready` on alternate cycles, injects a failure on a chosen program frame, and returns status bytes with non-busy bits set.

// File: rtl/fps_pkg.sv
package fps_pkg;
   localparam logic [7:0] OP_WEN  = 8'h06;
   localparam logic [7:0] OP_PROG = 8'h02;
   localparam logic [7:0] OP_STAT = 8'h05;

   localparam logic [1:0] RC_OK    = 2'd0;
   localparam logic [1:0] RC_RANGE = 2'd1;
   localparam logic [1:0] RC_XFER  = 2'd2;
   localparam logic [1:0] RC_TMO   = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE, ST_WEN, ST_WEN_W, ST_PHDR, ST_PDAT, ST_PROG_W, ST_SHDR, ST_STAT_W
   } fps_st_e;
endpackage

// File: rtl/fps_chunk.sv
module fps_chunk #(
   parameter int ADDR_W   = 24,
   parameter int LEN_W    = 16,
   parameter int PGL_W    = 4,
   parameter int MAX_LOG2 = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  remain,
   input  logic [PGL_W-1:0]  pg_log2,
   output logic [LEN_W-1:0]  chunk
);
   localparam int RW = MAX_LOG2 + 1;

   logic [RW-1:0] pg_bytes, offs, room;

   always_comb begin
      pg_bytes = RW'(1) << pg_log2;
      offs     = RW'(addr) & (pg_bytes - RW'(1));
      room     = pg_bytes - offs;
      chunk    = (LEN_W'(room) < remain) ? LEN_W'(room) : remain;
   end
endmodule

// File: rtl/fps_poll_timer.sv
module fps_poll_timer #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic busy_hit,
   output logic final_try
);
   generate
      if (LIMIT == 0) begin : g_off
         assign final_try = 1'b0;
      end else begin : g_on
         localparam int CW = $clog2(LIMIT + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt <= '0;
            else if (clr)      cnt <= '0;
            else if (busy_hit) cnt <= cnt + 1'b1;
         end
         assign final_try = (cnt == CW'(LIMIT - 1));
      end
   endgenerate
endmodule

// File: rtl/fps_prog_seq.sv
module fps_prog_seq
   import fps_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int LEN_W       = 16,
   parameter int FLASH_BYTES = 2**24,
   parameter int PGL_W       = 4,
   parameter int MAX_LOG2    = 12,
   parameter int DEF_LOG2    = 8,
   parameter int POLL_LIMIT  = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W:0]   req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [PGL_W-1:0]  req_pg_log2,
   output logic              resp_valid,
   output logic [1:0]        resp_err,
   input  logic              dat_valid,
   output logic              dat_ready,
   input  logic [7:0]        dat_byte,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [7:0]        cmd_byte,
   output logic              cmd_last,
   input  logic              fr_done,
   input  logic              fr_err,
   input  logic [7:0]        fr_rx
);
   localparam int REQ_W = ADDR_W + 1;
   localparam int SUM_W = ((REQ_W > LEN_W) ? REQ_W : LEN_W) + 1;
   localparam logic [SUM_W-1:0] CAP = SUM_W'(FLASH_BYTES);

   generate
      if (ADDR_W > 24 || ADDR_W < MAX_LOG2) begin : g_bad_addr
         $error("ADDR_W must lie between MAX_LOG2 and 24");
      end
      if (LEN_W < MAX_LOG2 + 1) begin : g_bad_len
         $error("LEN_W too small for the largest page");
      end
      if (DEF_LOG2 < 1 || DEF_LOG2 > MAX_LOG2 || MAX_LOG2 >= 2**PGL_W) begin : g_bad_pg
         $error("page exponent parameters inconsistent");
      end
      if (FLASH_BYTES < 1 || longint'(FLASH_BYTES) > (longint'(1) << ADDR_W)) begin : g_bad_cap
         $error("FLASH_BYTES outside the address space");
      end
   endgenerate

   fps_st_e            st;
   logic [1:0]         idx;
   logic [ADDR_W-1:0]  addr_q;
   logic [LEN_W-1:0]   rem_q, left_q, chunk;
   logic [PGL_W-1:0]   log2_q, log2_eff;
   logic [SUM_W-1:0]   req_end;
   logic               req_bad, final_try, busy_hit, tmr_clr;
   logic [23:0]        addr_fr;
   logic               unused_rx;

   assign unused_rx = ^fr_rx[7:1];
   assign addr_fr   = 24'(addr_q);
   assign req_ready = (st == ST_IDLE);
   assign req_end   = SUM_W'(req_addr[ADDR_W-1:0]) + SUM_W'(req_len);
   assign req_bad   = req_addr[REQ_W-1] || (req_end > CAP);

   always_comb begin
      if (req_pg_log2 == '0)                    log2_eff = PGL_W'(DEF_LOG2);
      else if (req_pg_log2 > PGL_W'(MAX_LOG2)) log2_eff = PGL_W'(MAX_LOG2);
      else                                      log2_eff = req_pg_log2;
   end

   fps_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PGL_W(PGL_W), .MAX_LOG2(MAX_LOG2)) u_chunk (
      .addr(addr_q), .remain(rem_q), .pg_log2(log2_q), .chunk(chunk)
   );

   assign busy_hit = (st == ST_STAT_W) && fr_done && !fr_err && fr_rx[0];
   assign tmr_clr  = (st != ST_STAT_W) && (st != ST_SHDR);

   fps_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .busy_hit(busy_hit), .final_try(final_try)
   );

   always_comb begin
      cmd_valid = 1'b0;
      cmd_byte  = 8'h00;
      cmd_last  = 1'b0;
      dat_ready = 1'b0;
      unique case (st)
         ST_WEN: begin
            cmd_valid = 1'b1;
            cmd_byte  = OP_WEN;
            cmd_last  = 1'b1;
         end
         ST_PHDR: begin
            cmd_valid = 1'b1;
            unique case (idx)
               2'd0: cmd_byte = OP_PROG;
               2'd1: cmd_byte = addr_fr[23:16];
               2'd2: cmd_byte = addr_fr[15:8];
               default: cmd_byte = addr_fr[7:0];
            endcase
         end
         ST_PDAT: begin
            cmd_valid = dat_valid;
            cmd_byte  = dat_byte;
            cmd_last  = (left_q == LEN_W'(1));
            dat_ready = cmd_ready;
         end
         ST_SHDR: begin
            cmd_valid = 1'b1;
            cmd_byte  = (idx == 2'd0) ? OP_STAT : 8'h00;
            cmd_last  = (idx == 2'd1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         idx        <= '0;
         addr_q     <= '0;
         rem_q      <= '0;
         left_q     <= '0;
         log2_q     <= '0;
         resp_valid <= 1'b0;
         resp_err   <= RC_OK;
      end else begin
         resp_valid <= 1'b0;
         unique case (st)
            ST_IDLE: if (req_valid) begin
               if (req_bad) begin
                  resp_valid <= 1'b1;
                  resp_err   <= RC_RANGE;
               end else if (req_len == '0) begin
                  resp_valid <= 1'b1;
                  resp_err   <= RC_OK;
               end else begin
                  addr_q <= req_addr[ADDR_W-1:0];
                  rem_q  <= req_len;
                  log2_q <= log2_eff;
                  st     <= ST_WEN;
               end
            end
            ST_WEN: if (cmd_ready) st <= ST_WEN_W;
            ST_WEN_W: if (fr_done) begin
               if (fr_err) begin
                  resp_valid <= 1'b1;
                  resp_err   <= RC_XFER;
                  st         <= ST_IDLE;
               end else begin
                  left_q <= chunk;
                  idx    <= '0;
                  st     <= ST_PHDR;
               end
            end
            ST_PHDR: if (cmd_ready) begin
               if (idx == 2'd3) st <= ST_PDAT;
               idx <= idx + 2'd1;
            end
            ST_PDAT: if (dat_valid && cmd_ready) begin
               addr_q <= addr_q + 1'b1;
               rem_q  <= rem_q - 1'b1;
               left_q <= left_q - 1'b1;
               if (left_q == LEN_W'(1)) st <= ST_PROG_W;
            end
            ST_PROG_W: if (fr_done) begin
               if (fr_err) begin
                  resp_valid <= 1'b1;
                  resp_err   <= RC_XFER;
                  st         <= ST_IDLE;
               end else begin
                  idx <= '0;
                  st  <= ST_SHDR;
               end
            end
            ST_SHDR: if (cmd_ready) begin
               if (idx == 2'd1) st <= ST_STAT_W;
               idx <= idx + 2'd1;
            end
            ST_STAT_W: if (fr_done) begin
               if (fr_err) begin
                  resp_valid <= 1'b1;
                  resp_err   <= RC_XFER;
                  st         <= ST_IDLE;
               end else if (fr_rx[0]) begin
                  if (final_try) begin
                     resp_valid <= 1'b1;
                     resp_err   <= RC_TMO;
                     st         <= ST_IDLE;
                  end else begin
                     idx <= '0;
                     st  <= ST_SHDR;
                  end
               end else if (rem_q == '0) begin
                  resp_valid <= 1'b1;
                  resp_err   <= RC_OK;
                  st         <= ST_IDLE;
               end else begin
                  st <= ST_WEN;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fps_prog_seq_chk.sv
module fps_prog_seq_chk
   import fps_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int LEN_W       = 16,
   parameter int FLASH_BYTES = 2**24,
   parameter int PGL_W       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W:0]   req_addr,
   input logic [LEN_W-1:0]  req_len,
   input logic              resp_valid,
   input logic [1:0]        resp_err,
   input logic              dat_ready,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [7:0]        cmd_byte,
   input logic              cmd_last,
   input fps_st_e           st,
   input logic [ADDR_W-1:0] addr_q,
   input logic [LEN_W-1:0]  left_q,
   input logic [PGL_W-1:0]  log2_q
);
   logic first_q, armed_q;
   longint end_c;
   logic   bad_c;

   assign end_c = longint'(req_addr[ADDR_W-1:0]) + longint'(req_len);
   assign bad_c = req_addr[ADDR_W] || (end_c > longint'(FLASH_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b1;
         armed_q <= 1'b0;
      end else if (cmd_valid && cmd_ready) begin
         first_q <= cmd_last;
         if (first_q && cmd_byte == OP_WEN && cmd_last) armed_q <= 1'b1;
         else if (first_q && cmd_byte == OP_PROG)      armed_q <= 1'b0;
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!cmd_valid && !dat_ready));

   a_r2_range_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && bad_c) |=> (resp_valid && resp_err == RC_RANGE));

   a_r4_within_page: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PHDR) |-> (left_q != '0 &&
         ((longint'(addr_q) & ((longint'(1) << log2_q) - 1)) + longint'(left_q))
            <= (longint'(1) << log2_q)));

   a_r6_wen_before_prog: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && first_q && cmd_byte == OP_PROG) |-> armed_q);

   a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);
endmodule

bind fps_prog_seq fps_prog_seq_chk #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FLASH_BYTES(FLASH_BYTES), .PGL_W(PGL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_addr(req_addr), .req_len(req_len), .resp_valid(resp_valid), .resp_err(resp_err),
   .dat_ready(dat_ready), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_byte(cmd_byte), .cmd_last(cmd_last), .st(st), .addr_q(addr_q),
   .left_q(left_q), .log2_q(log2_q)
);

// File: tb/sim_fps_prog_seq.sv
`timescale 1ns/1ps
module sim_fps_prog_seq;
   localparam int AW = 16, LW = 12, CAPB = 8192, PW = 4, MXL = 10, DFL = 8, LIM = 5;
   localparam int NLOG = 256;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [AW:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic [PW-1:0] req_pg_log2 = '0;
   logic resp_valid; logic [1:0] resp_err;
   logic dat_ready; logic [7:0] dat_byte;
   logic cmd_valid, cmd_last; logic [7:0] cmd_byte;
   logic cmd_ready;
   logic fr_done = 1'b0, fr_err = 1'b0; logic [7:0] fr_rx = 8'h00;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit stall = 1'b0;
   int d_idx = 0, base = 0, busy_cfg = 0, fail_pp = -1;
   int busy_left = 0, pp_cnt = 0, log_n = 0, mism = 0, fb_n = 0, pend = 0, pend_op = 0;
   logic [7:0] hdr [4];
   int lg_op [NLOG], lg_addr [NLOG], lg_len [NLOG];
   int ex_op [NLOG], ex_addr [NLOG], ex_len [NLOG];
   int ex_n = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 7 + 3) ^ (i >> 8));
   endfunction

   assign dat_byte  = pat(d_idx);
   assign cmd_ready = stall ? cyc[0] : 1'b1;

   fps_prog_seq #(.ADDR_W(AW), .LEN_W(LW), .FLASH_BYTES(CAPB), .PGL_W(PW),
                  .MAX_LOG2(MXL), .DEF_LOG2(DFL), .POLL_LIMIT(LIM)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_pg_log2(req_pg_log2),
      .resp_valid(resp_valid), .resp_err(resp_err), .dat_valid(1'b1),
      .dat_ready(dat_ready), .dat_byte(dat_byte), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_byte(cmd_byte), .cmd_last(cmd_last),
      .fr_done(fr_done), .fr_err(fr_err), .fr_rx(fr_rx));

   // command engine model
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (dat_ready) d_idx <= d_idx + 1;
      if (cmd_valid && cmd_ready) begin
         if (fb_n < 4) hdr[fb_n] <= cmd_byte;
         else if (hdr[0] == 8'h02 &&
                  cmd_byte !== pat({hdr[1], hdr[2], hdr[3]} + fb_n - 4 - base)) mism <= mism + 1;
         if (cmd_last) begin
            if (log_n < NLOG) begin
               lg_op[log_n]   <= (fb_n == 0) ? int'(cmd_byte) : int'(hdr[0]);
               lg_addr[log_n] <= (fb_n >= 4) ? int'({hdr[1], hdr[2], hdr[3]}) : 0;
               lg_len[log_n]  <= (fb_n >= 4) ? fb_n - 3 : 0;
            end
            log_n   <= log_n + 1;
            pend    <= 3;
            pend_op <= (fb_n == 0) ? int'(cmd_byte) : int'(hdr[0]);
            fb_n    <= 0;
         end else fb_n <= fb_n + 1;
      end
      fr_done <= 1'b0;
      if (pend > 1) pend <= pend - 1;
      else if (pend == 1) begin
         pend    <= 0;
         fr_done <= 1'b1;
         fr_err  <= 1'b0;
         fr_rx   <= 8'hFE;
         if (pend_op == 2) begin
            fr_err    <= (pp_cnt == fail_pp);
            pp_cnt    <= pp_cnt + 1;
            busy_left <= busy_cfg;
         end else if (pend_op == 5) begin
            fr_rx <= (busy_left > 0) ? 8'h03 : 8'hFE;
            if (busy_left > 0) busy_left <= busy_left - 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic add_ex(input int op, input int a, input int l);
      if (ex_n < NLOG) begin ex_op[ex_n] = op; ex_addr[ex_n] = a; ex_len[ex_n] = l; end
      ex_n++;
   endtask

   // expected frame list derived from R4..R10
   task automatic build(input int a0, input int len, input int lg, input int busy, input int fpp);
      int a = a0, r = len, pp = 0, pg;
      pg = 1 << ((lg == 0) ? DFL : lg);
      ex_n = 0;
      while (r > 0) begin
         int room = pg - (a % pg);
         int c = (r < room) ? r : room;
         add_ex(6, 0, 0);
         add_ex(2, a, c);
         if (pp == fpp) break;
         if (busy >= LIM) begin
            for (int k = 0; k < LIM; k++) add_ex(5, 0, 0);
            break;
         end
         for (int k = 0; k <= busy; k++) add_ex(5, 0, 0);
         a += c; r -= c; pp++;
      end
   endtask

   task automatic run(input int a, input int len, input int lg, input int busy,
                      input int fpp, input int exp_err, input bit frames, input string req);
      int waitc = 0;
      @(negedge clk);
      log_n = 0; mism = 0; pp_cnt = 0; d_idx = 0;
      base = a; busy_cfg = busy; fail_pp = fpp;
      req_addr = (AW+1)'(a); req_len = LW'(len); req_pg_log2 = PW'(lg); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!resp_valid && waitc < 20000) begin @(negedge clk); waitc++; end
      chk(resp_valid, {req, " response"}, 0, 1);
      chk(resp_err == 2'(exp_err), {req, " error code"}, int'(resp_err), exp_err);
      @(negedge clk);
      chk(!resp_valid, "R11 single pulse", int'(resp_valid), 0);
      repeat (12) @(negedge clk);
      if (frames) build(a, len, lg, busy, fpp); else ex_n = 0;
      chk(log_n == ex_n, {req, " frame count"}, log_n, ex_n);
      for (int i = 0; i < ex_n && i < log_n && i < NLOG; i++) begin
         chk(lg_op[i] == ex_op[i], {req, " R6 R8 frame opcode"}, lg_op[i], ex_op[i]);
         chk(lg_addr[i] == ex_addr[i], {req, " R7 frame address"}, lg_addr[i], ex_addr[i]);
         chk(lg_len[i] == ex_len[i], {req, " R4 chunk length"}, lg_len[i], ex_len[i]);
      end
      chk(mism == 0, {req, " R7 R12 data order"}, mism, 0);
      chk(req_ready, "R1 idle after response", int'(req_ready), 1);
   endtask

   task automatic t_reset;
      chk(req_ready, "R1 reset ready", int'(req_ready), 1);
      chk(!cmd_valid && !dat_ready, "R1 reset quiet", int'(cmd_valid), 0);
      chk(!resp_valid, "R11 reset resp", int'(resp_valid), 0);
   endtask

   task automatic t_default_page;   // R5 default page, R4 head/full/tail chunks
      run(32'h100, 256, 0, 2, -1, 0, 1'b1, "R5 aligned default page");
      stall = 1'b1;
      run(32'h1F0, 300, 0, 0, -1, 0, 1'b1, "R4 R12 unaligned default page");
      stall = 1'b0;
   endtask

   task automatic t_small_page;     // R5 exponent 4
      run(32'h405, 40, 4, 1, -1, 0, 1'b1, "R5 sixteen byte page");
   endtask

   task automatic t_range;          // R2 and R3
      run(8100, 100, 4, 0, -1, 1, 1'b0, "R2 past end");
      run(32'h1FFF0, 8, 4, 0, -1, 1, 1'b0, "R2 negative address");
      run(8092, 100, 4, 0, -1, 0, 1'b1, "R2 exactly at end");
      run(32'h30, 0, 0, 0, -1, 0, 1'b0, "R3 zero length");
   endtask

   task automatic t_fail;           // R9
      run(32'h40, 40, 4, 0, 1, 2, 1'b1, "R9 second program fails");
   endtask

   task automatic t_timeout;        // R10 and R8 non-busy bits
      run(32'h80, 20, 4, LIM - 1, -1, 0, 1'b1, "R10 one under limit");
      run(32'h80, 20, 4, LIM, -1, 3, 1'b1, "R10 poll timeout");
   endtask

   task automatic finish_run;
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_default_page;
      t_small_page;
      t_range;
      t_fail;
      t_timeout;
      finish_run;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      finish_run;
   end
endmodule